// File: doc/BRIEF.md
# Shared Segment Buffer Allocator

This block keeps track of which fixed-size segments of a packet buffer are free and hands them out to logical ports on request. The buffer is split into 256-byte segments, 512 in total by default, and each is named by a 9-bit index. No port owns a range of indices. Every free segment sits in one common pool, and a segment that one port releases can be granted next to any other port.

Each port has two configured limits. The quota is a hard cap: a request is refused while the port already holds that many segments. The threshold is a softer level: once the port's held count reaches it, the port's flow-control output rises, so upstream logic can slow that port before it meets its quota. Segments are requested and released through two independent request channels that may both fire in the same cycle. Quotas and thresholds are loaded through a small register write port.

Top module: `seg_pool_alloc`

## Requirements
- R1: After reset the whole pool is free (`pool_empty` low), every `fc_out` bit is low, and `alloc_valid` and `free_err` are low. After reset every port's quota and threshold both equal NUM_SEGS.
- R2: An allocation request is answered exactly one cycle later with `alloc_valid` high. `alloc_grant` is 1 for a grant and 0 for a denial, and `alloc_seg` carries the granted index, or zero on a denial.
- R3: Once reset is released, segments that have never been used are granted in ascending index order starting at 0. Freed segments are granted again before any never-used segment, most recently freed first.
- R4: A request from a port whose held count is already at or above its quota is denied, and the held count does not change.
- R5: `fc_out[p]` is high exactly when port p's held count is at or above its threshold. It changes in the same cycle as the held count and falls as soon as the count drops below the threshold.
- R6: A freed segment returns to the shared pool and can be granted to any port, including a port other than the one that released it.
- R7: When a port allocates and frees in the same cycle, its held count ends unchanged. If the pool already held a free segment, the grant comes from that pool, and the released segment becomes the next one to be handed out.
- R8: A free request for a port whose held count is zero raises `free_err` one cycle later and is otherwise ignored. The count stays at zero and the segment is not added to the pool.
- R9: When all segments are held, `pool_empty` is high and every request is denied. A segment freed in the same cycle as a request is not available to that request.
- R10: A register write with `cfg_sel`=0 loads the quota of port `cfg_port` and one with `cfg_sel`=1 loads its threshold. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one segment |
| alloc_port | input | PORT_W | Requesting logical port |
| alloc_valid | output | 1 | Response to the request of the previous cycle |
| alloc_grant | output | 1 | 1 = granted, 0 = denied |
| alloc_seg | output | SEG_W | Granted segment index |
| free_req | input | 1 | Release one segment |
| free_port | input | PORT_W | Port releasing the segment |
| free_seg | input | SEG_W | Index being released |
| free_err | output | 1 | Release of the previous cycle refused (count was zero) |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 1 | 0 = quota, 1 = threshold |
| cfg_port | input | PORT_W | Port whose limit is written |
| cfg_data | input | CNT_W | Limit value |
| fc_out | output | NUM_PORTS | Per-port flow control |
| pool_empty | output | 1 | No free segment remains |

## Verification
The assertions assume that callers only release segments they actually hold. A segment is never freed twice and never freed under a port that did not receive it, so the free stack cannot overflow. They also assume that inputs are defined from the first clock. The bench keeps to this by freeing only indices it earlier saw granted to that same port, plus one deliberate zero-count release whose segment is never pushed. Expected grants come from a model of an ascending fresh counter followed by a LIFO of released indices. The bench observes held counts through `fc_out` by moving thresholds up and down.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;
    typedef enum logic {
        LIM_QUOTA  = 1'b0,
        LIM_THRESH = 1'b1
    } lim_sel_e;
endpackage

// File: rtl/seg_free_stack.sv
module seg_free_stack #(
    parameter int NUM_SEGS = 512,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int CNT_W   = $clog2(NUM_SEGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [SEG_W-1:0] push_seg,
    output logic             avail,
    output logic [SEG_W-1:0] pop_seg
);
    typedef struct packed {
        logic [CNT_W-1:0] sp;
        logic [CNT_W-1:0] fresh;
    } stk_t;

    stk_t state_d, state_q;
    logic [SEG_W-1:0] mem [NUM_SEGS];
    logic             wr_en;
    logic [SEG_W-1:0] wr_addr;
    logic [CNT_W-1:0] sp_dec;

    assign sp_dec = state_q.sp - CNT_W'(1);

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        wr_addr = '0;
        avail   = (state_q.sp != '0) || (state_q.fresh != CNT_W'(NUM_SEGS));
        pop_seg = (state_q.sp != '0) ? mem[sp_dec[SEG_W-1:0]] : state_q.fresh[SEG_W-1:0];
        if (pop && push) begin
            wr_en = 1'b1;
            if (state_q.sp != '0) begin
                wr_addr = sp_dec[SEG_W-1:0];
            end else begin
                wr_addr       = '0;
                state_d.sp    = CNT_W'(1);
                state_d.fresh = state_q.fresh + CNT_W'(1);
            end
        end else if (pop) begin
            if (state_q.sp != '0) state_d.sp    = sp_dec;
            else                  state_d.fresh = state_q.fresh + CNT_W'(1);
        end else if (push) begin
            wr_en      = 1'b1;
            wr_addr    = state_q.sp[SEG_W-1:0];
            state_d.sp = state_q.sp + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= push_seg;
    end
endmodule

// File: rtl/seg_port_ledger.sv
module seg_port_ledger
    import seg_alloc_pkg::*;
#(
    parameter int NUM_PORTS = 64,
    parameter int NUM_SEGS  = 512,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int CNT_W    = $clog2(NUM_SEGS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic [PORT_W-1:0]    alloc_port,
    input  logic                 pool_avail,
    input  logic                 free_req,
    input  logic [PORT_W-1:0]    free_port,
    input  logic                 cfg_we,
    input  lim_sel_e             cfg_sel,
    input  logic [PORT_W-1:0]    cfg_port,
    input  logic [CNT_W-1:0]     cfg_data,
    output logic                 grant,
    output logic                 free_ok,
    output logic                 free_bad,
    output logic [NUM_PORTS-1:0] fc
);
    typedef struct packed {
        logic [NUM_PORTS-1:0][CNT_W-1:0] cnt;
        logic [NUM_PORTS-1:0][CNT_W-1:0] quota;
        logic [NUM_PORTS-1:0][CNT_W-1:0] thr;
    } ledger_t;

    ledger_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        grant    = alloc_req && pool_avail && (state_q.cnt[alloc_port] < state_q.quota[alloc_port]);
        free_ok  = free_req && (state_q.cnt[free_port] != '0);
        free_bad = free_req && (state_q.cnt[free_port] == '0);
        if (grant)   state_d.cnt[alloc_port] = state_d.cnt[alloc_port] + CNT_W'(1);
        if (free_ok) state_d.cnt[free_port]  = state_d.cnt[free_port] - CNT_W'(1);
        if (cfg_we) begin
            if (cfg_sel == LIM_THRESH) state_d.thr[cfg_port]   = cfg_data;
            else                       state_d.quota[cfg_port] = cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                state_q.cnt[p]   <= '0;
                state_q.quota[p] <= CNT_W'(NUM_SEGS);
                state_q.thr[p]   <= CNT_W'(NUM_SEGS);
            end
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_fc
        assign fc[g] = state_q.cnt[g] >= state_q.thr[g];
    end
endmodule

// File: rtl/seg_pool_alloc.sv
module seg_pool_alloc
    import seg_alloc_pkg::*;
#(
    parameter int NUM_PORTS = 64,
    parameter int NUM_SEGS  = 512,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int SEG_W    = $clog2(NUM_SEGS),
    localparam int CNT_W    = $clog2(NUM_SEGS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic [PORT_W-1:0]    alloc_port,
    output logic                 alloc_valid,
    output logic                 alloc_grant,
    output logic [SEG_W-1:0]     alloc_seg,
    input  logic                 free_req,
    input  logic [PORT_W-1:0]    free_port,
    input  logic [SEG_W-1:0]     free_seg,
    output logic                 free_err,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [PORT_W-1:0]    cfg_port,
    input  logic [CNT_W-1:0]     cfg_data,
    output logic [NUM_PORTS-1:0] fc_out,
    output logic                 pool_empty
);
    typedef struct packed {
        logic             valid;
        logic             grant;
        logic [SEG_W-1:0] seg;
        logic             ferr;
    } resp_t;

    resp_t            resp_d, resp_q;
    logic             grant_w, free_ok_w, free_bad_w, avail_w;
    logic [SEG_W-1:0] pop_seg_w;

    seg_free_stack #(.NUM_SEGS(NUM_SEGS)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (grant_w),
        .push     (free_ok_w),
        .push_seg (free_seg),
        .avail    (avail_w),
        .pop_seg  (pop_seg_w)
    );

    seg_port_ledger #(.NUM_PORTS(NUM_PORTS), .NUM_SEGS(NUM_SEGS)) u_ledger (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_req),
        .alloc_port (alloc_port),
        .pool_avail (avail_w),
        .free_req   (free_req),
        .free_port  (free_port),
        .cfg_we     (cfg_we),
        .cfg_sel    (lim_sel_e'(cfg_sel)),
        .cfg_port   (cfg_port),
        .cfg_data   (cfg_data),
        .grant      (grant_w),
        .free_ok    (free_ok_w),
        .free_bad   (free_bad_w),
        .fc         (fc_out)
    );

    always_comb begin
        resp_d.valid = alloc_req;
        resp_d.grant = grant_w;
        resp_d.seg   = grant_w ? pop_seg_w : '0;
        resp_d.ferr  = free_bad_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign alloc_valid = resp_q.valid;
    assign alloc_grant = resp_q.grant;
    assign alloc_seg   = resp_q.seg;
    assign free_err    = resp_q.ferr;
    assign pool_empty  = !avail_w;
endmodule

// File: rtl/seg_pool_alloc_chk.sv
module seg_pool_alloc_chk #(
    parameter int NUM_PORTS = 64,
    parameter int NUM_SEGS  = 512,
    localparam int SEG_W    = $clog2(NUM_SEGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_req,
    input logic                 alloc_valid,
    input logic                 alloc_grant,
    input logic [SEG_W-1:0]     alloc_seg,
    input logic                 free_req,
    input logic                 free_err,
    input logic                 cfg_we,
    input logic [NUM_PORTS-1:0] fc_out,
    input logic                 pool_empty
);
    assert_req_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> alloc_valid);
    assert_resp_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |-> $past(alloc_req));
    assert_deny_seg_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_grant) |-> (alloc_seg == '0));
    assert_empty_denies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && pool_empty) |=> !alloc_grant);
    assert_ferr_has_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        free_err |-> $past(free_req));
    assert_fc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_req && !free_req && !cfg_we) |=> $stable(fc_out));
endmodule

bind seg_pool_alloc seg_pool_alloc_chk #(.NUM_PORTS(NUM_PORTS), .NUM_SEGS(NUM_SEGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .alloc_valid (alloc_valid),
    .alloc_grant (alloc_grant),
    .alloc_seg   (alloc_seg),
    .free_req    (free_req),
    .free_err    (free_err),
    .cfg_we      (cfg_we),
    .fc_out      (fc_out),
    .pool_empty  (pool_empty)
);

// File: tb/seg_pool_alloc_bench.sv
module seg_pool_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PORTS  = 64;
    localparam int NUM_SEGS   = 512;
    localparam int PORT_W     = $clog2(NUM_PORTS);
    localparam int SEG_W      = $clog2(NUM_SEGS);
    localparam int CNT_W      = $clog2(NUM_SEGS + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 alloc_req = 1'b0;
    logic [PORT_W-1:0]    alloc_port = '0;
    logic                 alloc_valid, alloc_grant;
    logic [SEG_W-1:0]     alloc_seg;
    logic                 free_req = 1'b0;
    logic [PORT_W-1:0]    free_port = '0;
    logic [SEG_W-1:0]     free_seg = '0;
    logic                 free_err;
    logic                 cfg_we = 1'b0;
    logic                 cfg_sel = 1'b0;
    logic [PORT_W-1:0]    cfg_port = '0;
    logic [CNT_W-1:0]     cfg_data = '0;
    logic [NUM_PORTS-1:0] fc_out;
    logic                 pool_empty;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    logic [SEG_W:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_pool_alloc #(.NUM_PORTS(NUM_PORTS), .NUM_SEGS(NUM_SEGS)) u_seg_pool_alloc (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_port(alloc_port),
        .alloc_valid(alloc_valid), .alloc_grant(alloc_grant), .alloc_seg(alloc_seg),
        .free_req(free_req), .free_port(free_port), .free_seg(free_seg), .free_err(free_err),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_port(cfg_port), .cfg_data(cfg_data),
        .fc_out(fc_out), .pool_empty(pool_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives one cycle of requests at a falling edge and returns at the next falling edge.
    task automatic cyc(input bit a, input int ap, input bit g, input int seg, input string tag,
                       input bit f, input int fp, input int fs);
        alloc_req  = a;
        alloc_port = PORT_W'(ap);
        free_req   = f;
        free_port  = PORT_W'(fp);
        free_seg   = SEG_W'(fs);
        if (a) begin
            exp_q.push_back({g, g ? SEG_W'(seg) : SEG_W'(0)});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        alloc_req = 1'b0;
        free_req  = 1'b0;
    endtask

    task automatic alloc(input int ap, input bit g, input int seg, input string tag);
        cyc(1'b1, ap, g, seg, tag, 1'b0, 0, 0);
    endtask

    task automatic release_seg(input int fp, input int fs);
        cyc(1'b0, 0, 1'b0, 0, "", 1'b1, fp, fs);
    endtask

    task automatic cfg(input int p, input bit sel, input int val);
        cfg_we   = 1'b1;
        cfg_sel  = sel;
        cfg_port = PORT_W'(p);
        cfg_data = CNT_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: pops expected responses as the design produces them.
    always @(negedge clk) begin
        if (rst_n && alloc_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 32'(alloc_valid), 32'(0));
            end else begin
                logic [SEG_W:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'({alloc_grant, alloc_seg}), 32'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pool_empty", 32'(pool_empty), 32'(0));
        check("R1 fc_out", 32'(fc_out != '0), 32'(0));
        check("R1 alloc_valid", 32'(alloc_valid), 32'(0));
        check("R1 free_err", 32'(free_err), 32'(0));

        // R10 limits for port 1: quota 3, threshold 2
        cfg(1, 1'b0, 3);
        cfg(1, 1'b1, 2);
        alloc(1, 1'b1, 0, "R3 fresh grant 0");
        check("R5 fc below thr", 32'(fc_out[1]), 32'(0));
        alloc(1, 1'b1, 1, "R3 fresh grant 1");
        check("R5 fc at thr", 32'(fc_out[1]), 32'(1));
        alloc(1, 1'b1, 2, "R3 fresh grant 2");
        alloc(1, 1'b0, 0, "R4 quota deny");
        check("R4 count unchanged fc", 32'(fc_out[1]), 32'(1));

        release_seg(1, 1);
        check("R5 fc still at thr", 32'(fc_out[1]), 32'(1));
        release_seg(1, 0);
        check("R5 fc drops below thr", 32'(fc_out[1]), 32'(0));

        // R6 reuse by another port, LIFO order
        alloc(5, 1'b1, 0, "R6 reuse last freed");
        alloc(5, 1'b1, 1, "R3 reuse next freed");
        alloc(5, 1'b1, 3, "R3 fresh after pool drained");

        // R8 free at zero count
        release_seg(7, 9);
        check("R8 free_err", 32'(free_err), 32'(1));
        check("R8 fc port7", 32'(fc_out[7]), 32'(0));
        alloc(7, 1'b1, 4, "R8 bad free not pooled");
        @(negedge clk);
        check("R8 free_err clears", 32'(free_err), 32'(0));

        // R7 same-cycle allocate and free on port 1 (holds seg 2)
        cyc(1'b1, 1, 1'b1, 5, "R7 grant with free", 1'b1, 1, 2);
        check("R7 no free_err", 32'(free_err), 32'(0));
        cfg(1, 1'b1, 1);
        @(negedge clk);
        check("R7 count one fc on", 32'(fc_out[1]), 32'(1));
        cfg(1, 1'b1, 2);
        @(negedge clk);
        check("R7 count one fc off", 32'(fc_out[1]), 32'(0));
        alloc(9, 1'b1, 2, "R7 freed seg pooled");

        // R9 exhaust the pool from port 10
        for (int s = 6; s < NUM_SEGS; s++) alloc(10, 1'b1, s, "R9 fill");
        check("R9 pool_empty", 32'(pool_empty), 32'(1));
        check("R5 default thr not reached", 32'(fc_out[10]), 32'(0));
        alloc(20, 1'b0, 0, "R9 empty deny");
        cyc(1'b1, 21, 1'b0, 0, "R9 same-cycle free not usable", 1'b1, 10, 100);
        check("R9 pool refilled", 32'(pool_empty), 32'(0));
        alloc(20, 1'b1, 100, "R6 cross-port reuse");
        check("R9 empty again", 32'(pool_empty), 32'(1));

        repeat (2) @(negedge clk);
        check("R2 all responses seen", 32'(exp_q.size()), 32'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule